// File: doc/BRIEF.md
# BCD Timekeeping Core

This block keeps wall-clock time and a calendar as seven packed-BCD bytes: seconds, minutes, hours, weekday, day of month, month and two-digit year. A prescaler counts single-cycle pulses on an oscillator-enable input. After a parameterised number of pulses (32768 by default) it issues a one-second tick, and the tick ripples through the counters with the usual carries. Months have their proper lengths, and February has 29 days in years divisible by four. The hours byte carries a mode flag that selects a 12-hour encoding with a PM flag or a 24-hour encoding.

Software or a bus slave loads new values through a plain single-cycle write port. The port is always accepted and has no back-pressure: the loaded byte appears on the outputs the cycle after the write strobe. The top bit of the seconds byte is a halt flag that freezes both the prescaler and all counting. Any load of the seconds byte also restarts the sub-second count, so the following tick arrives one full second later. All seven bytes are driven continuously on output ports. Bits defined as zero are masked on load.

Top module: `rtc_core`

## Requirements
- R1: After reset the outputs read seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: While the halt flag (seconds bit 7) is 0, seconds advance by one in BCD every DIV pulses of osc_en, and 59 wraps to 00 with a carry into minutes. No counter changes in other cycles except through a load.
- R3: Minutes wrap 59 to 00 with a carry into hours. In 24-hour mode (hours bit 6 = 0, bits 5:0 are the BCD hour) hours run 00 to 23, and 23 to 00 advances the day.
- R4: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, bits 4:0 are the BCD hour 01 to 12) the hour goes 12 to 01 with PM kept, and 11 to 12 with PM toggled. Only the 11 PM to 12 AM step advances the day.
- R5: The weekday counts 1 to 7, wraps 7 to 1, and steps on exactly the events that advance the date.
- R6: The date wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11; 29 for month 02 when the BCD year is a multiple of four, else 28; 31 otherwise. The wrap advances the month.
- R7: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: While the halt flag is 1, no byte changes except through a load, and the sub-second count is frozen.
- R9: A load of the seconds byte clears the sub-second count and suppresses the tick in that cycle, so the next advance comes after another DIV pulses of osc_en.
- R10: A write of wr_data at wr_addr 0 to 6 (seconds, minutes, hours, weekday, date, month, year) shows on the output the next cycle and takes priority over a tick for that byte. Address 7 is ignored. Bit positions defined as zero (minutes 7, hours 7, weekday 7:3, date 7:6, month 7:5) read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Load strobe, one byte per cycle |
| wr_addr | input | 3 | Byte selector for the load |
| wr_data | input | 8 | Packed-BCD value to load |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode, PM or tens-of-20, BCD hour |
| dow_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The range and carry assertions assume that every loaded byte is a legal packed-BCD value for its field, after masking. Their behaviour for out-of-range loads is unspecified. To stay within that assumption, the stimulus first halts the clock and then sets every field to a legal near-rollover value. It releases the halt with the seconds load last, so no tick can land on a half-built time. The only deliberately illegal bits the stimulus writes sit in positions defined as zero, which the load path masks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_DOW = 3'd3,
    A_DATE = 3'd4, A_MONTH = 3'd5, A_YEAR = 3'd6
  } rtc_addr_e;

  localparam logic [7:0] MSK_MIN   = 8'h7F;
  localparam logic [7:0] MSK_HOUR  = 8'h7F;
  localparam logic [7:0] MSK_DOW   = 8'h07;
  localparam logic [7:0] MSK_DATE  = 8'h3F;
  localparam logic [7:0] MSK_MONTH = 8'h1F;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    logic [7:0] r;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic halt,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = osc_en && !halt && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (osc_en && !halt)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !clr |=> $stable(cnt)); // R8
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R9
endmodule

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_tick
);
  logic sec_wrap, min_wrap, hour_end;
  logic [7:0] hv, hinc, hour_nx;
  logic wr_sec, wr_min, wr_hour;

  assign wr_sec  = wr_en && wr_addr == A_SEC;
  assign wr_min  = wr_en && wr_addr == A_MIN;
  assign wr_hour = wr_en && wr_addr == A_HOUR;
  assign sec_wrap = sec_q[6:0] == 7'h59;
  assign min_wrap = min_q == 8'h59;

  always_comb begin
    if (hour_q[6]) begin
      hv   = {3'b000, hour_q[4:0]};
      hinc = bcd_inc(hv);
      hour_end = (hv == 8'h11) && hour_q[5];
      if (hv == 8'h12)      hour_nx = {2'b01, hour_q[5], 5'h01};
      else if (hv == 8'h11) hour_nx = {2'b01, ~hour_q[5], 5'h12};
      else                  hour_nx = {2'b01, hour_q[5], hinc[4:0]};
    end else begin
      hv   = {2'b00, hour_q[5:0]};
      hinc = bcd_inc(hv);
      hour_end = hv == 8'h23;
      hour_nx  = hour_end ? 8'h00 : {2'b00, hinc[5:0]};
    end
  end

  assign day_tick = tick && sec_wrap && min_wrap && hour_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec)    sec_q <= wr_data;
      else if (tick) sec_q <= {sec_q[7], sec_wrap ? 7'h00 : bcd_inc({1'b0, sec_q[6:0]})};
      if (wr_min)                min_q <= wr_data & MSK_MIN;
      else if (tick && sec_wrap) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (wr_hour)                           hour_q <= wr_data & MSK_HOUR;
      else if (tick && sec_wrap && min_wrap) hour_q <= hour_nx;
    end
  end

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_sec |=> $stable(sec_q)); // R2
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && sec_wrap) && !wr_min |=> $stable(min_q)); // R3
  AST_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick && !wr_hour |=> (hour_q == 8'h00 || hour_q == 8'h52)); // R4
  AST_ZERO_BITS_T: assert property (@(posedge clk) disable iff (!rst_n)
    !min_q[7] && !hour_q[7]); // R10
endmodule

// File: rtl/rtc_date_ctr.sv
module rtc_date_ctr
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);
  logic date_end, month_end;
  logic wr_dow, wr_date, wr_month, wr_year;

  assign wr_dow   = wr_en && wr_addr == A_DOW;
  assign wr_date  = wr_en && wr_addr == A_DATE;
  assign wr_month = wr_en && wr_addr == A_MONTH;
  assign wr_year  = wr_en && wr_addr == A_YEAR;
  assign date_end  = date_q == last_day(month_q, year_q);
  assign month_end = month_q == 8'h12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_dow)        dow_q <= wr_data & MSK_DOW;
      else if (day_tick) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (wr_date)       date_q <= wr_data & MSK_DATE;
      else if (day_tick) date_q <= date_end ? 8'h01 : bcd_inc(date_q);
      if (wr_month)                  month_q <= wr_data & MSK_MONTH;
      else if (day_tick && date_end) month_q <= month_end ? 8'h01 : bcd_inc(month_q);
      if (wr_year) year_q <= wr_data;
      else if (day_tick && date_end && month_end)
        year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  AST_DOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick && !wr_dow |=> dow_q != $past(dow_q)); // R5
  AST_DATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    date_q != 8'h00 && month_q != 8'h00); // R6
  AST_YEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !day_tick && !wr_year |=> $stable(year_q)); // R7
  AST_ZERO_BITS_D: assert property (@(posedge clk) disable iff (!rst_n)
    dow_q[7:3] == 5'd0 && date_q[7:6] == 2'd0 && month_q[7:5] == 3'd0); // R10
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic tick, day_tick, sec_load;

  assign sec_load = wr_en && wr_addr == A_SEC;

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(sec_o[7]),
    .clr(sec_load), .tick(tick)
  );

  rtc_time_ctr u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .day_tick(day_tick)
  );

  rtc_date_ctr u_date (
    .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dow_q(dow_o), .date_q(date_o),
    .month_q(month_o), .year_q(year_o)
  );

  AST_HALT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] && !wr_en |=> $stable(sec_o) && $stable(min_o) && $stable(date_o)); // R8
endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  rtc_core #(.DIV(DIV)) i_rtc_core (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_ch, m_sec, m_min, m_hr, m_pm, m_m12, m_dow, m_date, m_mon, m_yr, m_pc;

  function automatic logic [7:0] bcd(int v); return 8'(((v / 10) << 4) | (v % 10)); endfunction
  function automatic int dec(logic [7:0] b); return int'(b[7:4]) * 10 + int'(b[3:0]); endfunction
  function automatic int mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] exp_hour();
    logic [7:0] b = bcd(m_hr);
    if (m_m12 != 0) return {1'b0, 1'b1, m_pm[0], b[4:0]};
    return {2'b00, b[5:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ch = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_m12 = 0;
      m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_pc = 0;
    end else begin
      bit swr, tk, cday, cmon;
      swr = wr_en && wr_addr == 3'd0;
      tk = osc_en && m_ch == 0 && m_pc == DIV - 1 && !swr;
      if (swr) m_pc = 0;
      else if (osc_en && m_ch == 0) m_pc = (m_pc + 1) % DIV;
      if (tk) begin
        cday = 0;
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0;
            if (m_m12 != 0) begin
              if (m_hr == 11) begin m_hr = 12; cday = (m_pm != 0); m_pm = 1 - m_pm; end
              else if (m_hr == 12) m_hr = 1;
              else m_hr++;
            end else begin
              m_hr++;
              if (m_hr == 24) begin m_hr = 0; cday = 1; end
            end
          end
        end
        if (cday) begin
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          cmon = (m_date == mdays(m_mon, m_yr));
          m_date = cmon ? 1 : m_date + 1;
          if (cmon) begin
            if (m_mon == 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
            else m_mon++;
          end
        end
      end
      if (wr_en) case (wr_addr)
        3'd0: begin m_ch = int'(wr_data[7]); m_sec = dec(wr_data & 8'h7F); end
        3'd1: m_min = dec(wr_data & 8'h7F);
        3'd2: begin
          m_m12 = int'(wr_data[6]);
          if (wr_data[6]) begin m_pm = int'(wr_data[5]); m_hr = dec(wr_data & 8'h1F); end
          else m_hr = dec(wr_data & 8'h3F);
        end
        3'd3: m_dow = int'(wr_data & 8'h07);
        3'd4: m_date = dec(wr_data & 8'h3F);
        3'd5: m_mon = dec(wr_data & 8'h1F);
        3'd6: m_yr = dec(wr_data);
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (cmp_on && rst_n) begin
    logic [63:0] act, exp;
    act = {8'h0, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    exp = {8'h0, m_ch[0], bcd(m_sec)[6:0], bcd(m_min), exp_hour(), 8'(m_dow),
           bcd(m_date), bcd(m_mon), bcd(m_yr)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s model actual=%h expected=%h", cur_req, act, exp);
    end
  end

  initial begin
    @(posedge rst_n);
    forever begin @(posedge clk); #1 osc_en = ~osc_en; end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic setup(logic [7:0] hr, logic [7:0] dw, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    wr(3'd0, 8'h80); wr(3'd1, 8'h59); wr(3'd2, hr); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, 8'h58);
    repeat (40) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "sec", sec_o, 8'h00); chk("R1", "hour", hour_o, 8'h00);
    chk("R1", "dow", dow_o, 8'h01); chk("R1", "date", date_o, 8'h01);
    chk("R1", "month", month_o, 8'h01); chk("R1", "year", year_o, 8'h00);
    rst_n = 1; cmp_on = 1;
    cur_req = "R2";
    repeat (40) @(posedge clk); @(negedge clk);
    chk("R2", "sec after two seconds", sec_o, 8'h02);

    cur_req = "R3";
    setup(8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    chk("R3", "hour 24h midnight", hour_o, 8'h00); chk("R3", "min", min_o, 8'h00);
    chk("R5", "dow 7->1", dow_o, 8'h01); chk("R7", "month", month_o, 8'h01);
    chk("R7", "year 99->00", year_o, 8'h00); chk("R6", "date", date_o, 8'h01);

    cur_req = "R4";
    setup(8'h71, 8'h03, 8'h28, 8'h02, 8'h24);
    chk("R4", "11PM->12AM", hour_o, 8'h52); chk("R5", "dow step", dow_o, 8'h04);
    chk("R6", "leap feb 29", date_o, 8'h29);
    setup(8'h51, 8'h03, 8'h15, 8'h06, 8'h24);
    chk("R4", "11AM->12PM", hour_o, 8'h72); chk("R4", "no day step", date_o, 8'h15);
    setup(8'h72, 8'h03, 8'h15, 8'h06, 8'h24);
    chk("R4", "12PM->1PM", hour_o, 8'h61);

    cur_req = "R6";
    setup(8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    chk("R6", "feb 28 common", date_o, 8'h01); chk("R6", "march", month_o, 8'h03);
    setup(8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
    chk("R6", "april 30", date_o, 8'h01); chk("R6", "may", month_o, 8'h05);

    cur_req = "R8";
    wr(3'd0, 8'h85);
    repeat (40) @(posedge clk); @(negedge clk);
    chk("R8", "halted sec", sec_o, 8'h85);

    cur_req = "R9";
    wr(3'd0, 8'h10);
    repeat (10) @(posedge clk); @(negedge clk);
    chk("R9", "before full second", sec_o, 8'h10);
    repeat (21) @(posedge clk); @(negedge clk);
    wr(3'd0, 8'h30);
    repeat (12) @(posedge clk); @(negedge clk);
    chk("R9", "restarted count", sec_o, 8'h30);
    repeat (8) @(posedge clk); @(negedge clk);
    chk("R9", "one second after load", sec_o, 8'h31);

    cur_req = "R10";
    wr(3'd0, 8'h80); wr(3'd1, 8'hD9); wr(3'd3, 8'hFB); wr(3'd4, 8'hC9); wr(3'd5, 8'hE7);
    @(negedge clk);
    chk("R10", "min mask", min_o, 8'h59); chk("R10", "dow mask", dow_o, 8'h03);
    chk("R10", "date mask", date_o, 8'h09); chk("R10", "month mask", month_o, 8'h07);
    wr(3'd7, 8'h12);
    @(negedge clk);
    chk("R10", "addr 7 ignored", year_o, bcd(m_yr)); chk("R10", "addr 7 sec", sec_o, 8'h80);

    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule